// File: doc/BRIEF.md
# Guarded Hybrid Priority Scheduler

This block picks which of a small set of per-slice egress queues sends its next packet. Queue 0 is the strict class: it wins whenever it may send, except when a guard steps in. Queues 1 to NQ-1 are weighted classes. They share what is left through deficit round robin, using a quantum for each queue. Each queue is also shaped by two token buckets. One refills at the committed rate and the other at the peak rate, and each is capped by its own burst size. A queue is eligible only while both buckets hold at least the length of its head packet.

Every cycle the block looks at the per-queue backlog flags and head-packet lengths and may issue one grant, which carries a valid flag and a queue index. A guard counts consecutive strict grants. After MIN_SVC of them in a row, the next decision goes to the weighted classes if any of them is eligible. Per-queue grant counters and both bucket levels are exported, so the contract being enforced can be observed. The surrounding queue manager dequeues the granted packet and updates the flags. Buckets refill on each pulse of `tick`.

Top module: `hybrid_sched`

## Requirements
- R1: After a synchronous active-low reset, `grant_valid` is 0, every service counter is 0, and every committed and peak bucket level is 0.
- R2: At most one grant is issued per cycle. A grant appears on the cycle after the decision. Its index names a queue whose non-empty flag was high at the decision, and queues with the flag low receive no grant.
- R3: On a cycle with `tick` high, each committed bucket gains its committed increment and each peak bucket gains its peak increment. The committed bucket saturates at its committed burst size and the peak bucket at its peak burst size.
- R4: A queue is granted only if both of its buckets hold at least its head length. Each grant subtracts that head length from both buckets of the granted queue.
- R5: Queue 0 is the strict class. When it is eligible and the guard is not active, it receives the grant ahead of every weighted queue.
- R6: After MIN_SVC consecutive grants to queue 0, if any weighted queue is eligible, the next grant does not go to queue 0. A weighted grant restarts the count.
- R7: Weighted queues 1..NQ-1 are served by deficit round robin. A queue is granted while its deficit covers its head length, and that length is then debited. When no eligible weighted queue can be served, a refill cycle adds each backlogged queue's quantum and issues no grant. An empty queue's deficit is cleared. With equal lengths and a steady backlog, the grant shares follow the quanta.
- R8: `svc_count` field q (bits q*CNT_W upward) increments by exactly one for each grant to queue q and otherwise holds.
- R9: With `tick` high every cycle, the strict queue's grants over T cycles never exceed (committed burst + T*committed increment)/head length. Cycles it cannot use go to the weighted queues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Bucket refill strobe |
| q_nonempty | input | NQ | Backlog flag per queue, bit q for queue q |
| head_len | input | NQ*LEN_W | Head-packet length per queue, field q at bits q*LEN_W |
| cir_inc | input | NQ*TOK_W | Committed refill increment per queue |
| cir_burst | input | NQ*TOK_W | Committed burst size per queue |
| pir_inc | input | NQ*TOK_W | Peak refill increment per queue |
| pir_burst | input | NQ*TOK_W | Peak burst size per queue |
| quantum | input | (NQ-1)*DEF_W | Deficit quantum, field k for queue k+1 |
| grant_valid | output | 1 | A grant is issued this cycle |
| grant_idx | output | $clog2(NQ) | Index of the granted queue |
| svc_count | output | NQ*CNT_W | Grants issued per queue |
| tok_cir | output | NQ*TOK_W | Committed bucket level per queue |
| tok_pir | output | NQ*TOK_W | Peak bucket level per queue |

## Verification
The hardest state to reach from the ports is the guard boundary. The strict queue must hold enough tokens to win MIN_SVC decisions in a row while a weighted queue stays eligible but short of deficit, so that the forced turn first costs a refill cycle and only then produces a weighted grant. The stimulus keeps queues 0 and 1 backlogged with large, fast-refilling buckets. It then measures the longest run of strict grants and the share that the weighted queue still gets. A second scenario starves the strict committed bucket, so the rate cap, rather than the guard, is what hands cycles to the weighted queues.

// File: rtl/hs_pkg.sv
// Shared definitions for the hybrid scheduler.
// Assumes: nothing beyond IEEE 1800-2017.
package hs_pkg;
    // Outcome of one decision slot.
    typedef enum logic [1:0] {
        DEC_IDLE     = 2'd0,
        DEC_STRICT   = 2'd1,
        DEC_WEIGHTED = 2'd2,
        DEC_REFILL   = 2'd3
    } dec_e;
endpackage

// File: rtl/rate_bucket.sv
// One token bucket: adds inc on each tick, saturates at cap and debits a packet length on take.
// Assumes: take is raised only when enough was high in the same cycle; TOK_W >= LEN_W.
module rate_bucket #(
    parameter int TOK_W = 16,
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [TOK_W-1:0] inc,
    input  logic [TOK_W-1:0] cap,
    input  logic [LEN_W-1:0] need_len,
    input  logic             take,
    output logic [TOK_W-1:0] level,
    output logic             enough
);
    logic [TOK_W:0] after_take;
    logic [TOK_W:0] after_add;
    logic [TOK_W:0] debit;
    logic [TOK_W:0] credit;

    // Eligibility compare against the head packet.
    assign enough = level >= TOK_W'(need_len);

    // Next level: debit first, then credit, then clamp to the burst size.
    always_comb begin
        debit      = take ? (TOK_W+1)'(need_len) : '0;
        credit     = tick ? {1'b0, inc} : '0;
        after_take = {1'b0, level} - debit;
        after_add  = after_take + credit;
    end

    // Level register.
    always_ff @(posedge clk) begin
        if (!rst_n)                       level <= '0;
        else if (after_add > {1'b0, cap}) level <= cap;
        else                              level <= after_add[TOK_W-1:0];
    end

    p_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> level <= $past(cap));
    p_take_covered_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> enough);
endmodule

// File: rtl/wdrr_pick.sv
// Deficit round robin over the weighted queues. It offers one candidate per cycle,
// starting the search at the last served queue, and holds a deficit per queue.
// Assumes: do_grant and do_refill come from the parent and are never high together;
// do_grant is high only when has_cand is high; DEF_W >= LEN_W.
module wdrr_pick #(
    parameter int NW    = 3,
    parameter int LEN_W = 12,
    parameter int DEF_W = 16,
    localparam int PW   = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NW-1:0]       nonempty,
    input  logic [NW-1:0]       elig,
    input  logic [NW*LEN_W-1:0] head_len,
    input  logic [NW*DEF_W-1:0] quantum,
    input  logic                do_grant,
    input  logic                do_refill,
    output logic                has_cand,
    output logic [PW-1:0]       cand_idx,
    output logic                any_elig
);
    logic [DEF_W-1:0] deficit [NW];
    logic [PW-1:0]    ptr;

    function automatic int wrap_idx(input int base, input int step);
        int s;
        s = base + step;
        if (s >= NW) s = s - NW;
        return s;
    endfunction

    assign any_elig = |elig;

    // Round-robin search for the first queue whose deficit covers its head packet.
    always_comb begin
        has_cand = 1'b0;
        cand_idx = ptr;
        for (int k = 0; k < NW; k++) begin
            if (!has_cand && elig[wrap_idx(int'(ptr), k)] &&
                deficit[wrap_idx(int'(ptr), k)] >=
                    DEF_W'(head_len[wrap_idx(int'(ptr), k)*LEN_W +: LEN_W])) begin
                has_cand = 1'b1;
                cand_idx = PW'(wrap_idx(int'(ptr), k));
            end
        end
    end

    // Search start: stay on the served queue while its deficit lasts.
    always_ff @(posedge clk) begin
        if (!rst_n)        ptr <= '0;
        else if (do_grant) ptr <= cand_idx;
    end

    for (genvar i = 0; i < NW; i++) begin : g_def
        logic [DEF_W:0] topped;
        assign topped = {1'b0, deficit[i]} + {1'b0, quantum[i*DEF_W +: DEF_W]};

        // Deficit per queue: clear on empty, debit on grant, add quantum on refill.
        always_ff @(posedge clk) begin
            if (!rst_n || !nonempty[i])
                deficit[i] <= '0;
            else if (do_grant && cand_idx == PW'(i))
                deficit[i] <= deficit[i] - DEF_W'(head_len[i*LEN_W +: LEN_W]);
            else if (do_refill)
                deficit[i] <= topped[DEF_W] ? '1 : topped[DEF_W-1:0];
        end
    end

    p_grant_needs_cand_r7: assert property (@(posedge clk) disable iff (!rst_n)
        do_grant |-> has_cand);
    p_refill_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(do_grant && do_refill));
    p_refill_only_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        do_refill |-> (any_elig && !has_cand));
endmodule

// File: rtl/hybrid_sched.sv
// Hybrid egress scheduler: queue 0 is strict and capped by its own buckets plus
// a minimum-service guard, and queues 1..NQ-1 share by deficit round robin. Every queue
// is dual-rate shaped. One registered grant per cycle.
// Assumes: NQ >= 2; quanta are non-zero; flags and lengths are stable per cycle;
// the parent dequeues the granted head before the flags are next sampled.
module hybrid_sched
    import hs_pkg::*;
#(
    parameter int NQ      = 4,
    parameter int LEN_W   = 12,
    parameter int TOK_W   = 16,
    parameter int DEF_W   = 16,
    parameter int CNT_W   = 32,
    parameter int MIN_SVC = 3,
    localparam int IDX_W  = $clog2(NQ),
    localparam int NW     = NQ - 1,
    localparam int PW     = (NW > 1) ? $clog2(NW) : 1,
    localparam int RUN_W  = $clog2(MIN_SVC + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic [NQ-1:0]         q_nonempty,
    input  logic [NQ*LEN_W-1:0]   head_len,
    input  logic [NQ*TOK_W-1:0]   cir_inc,
    input  logic [NQ*TOK_W-1:0]   cir_burst,
    input  logic [NQ*TOK_W-1:0]   pir_inc,
    input  logic [NQ*TOK_W-1:0]   pir_burst,
    input  logic [NW*DEF_W-1:0]   quantum,
    output logic                  grant_valid,
    output logic [IDX_W-1:0]      grant_idx,
    output logic [NQ*CNT_W-1:0]   svc_count,
    output logic [NQ*TOK_W-1:0]   tok_cir,
    output logic [NQ*TOK_W-1:0]   tok_pir
);
    logic [NQ-1:0]    c_ok, p_ok, elig, take;
    logic             w_cand, w_any, force_w, grant_now;
    logic [PW-1:0]    w_idx;
    logic [IDX_W-1:0] pick_idx;
    logic [RUN_W-1:0] run_cnt;
    dec_e             dec;

    // Dual-rate shaping: a committed and a peak bucket for each queue.
    for (genvar q = 0; q < NQ; q++) begin : g_q
        rate_bucket #(.TOK_W(TOK_W), .LEN_W(LEN_W)) u_cir (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .inc(cir_inc[q*TOK_W +: TOK_W]), .cap(cir_burst[q*TOK_W +: TOK_W]),
            .need_len(head_len[q*LEN_W +: LEN_W]), .take(take[q]),
            .level(tok_cir[q*TOK_W +: TOK_W]), .enough(c_ok[q]));
        rate_bucket #(.TOK_W(TOK_W), .LEN_W(LEN_W)) u_pir (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .inc(pir_inc[q*TOK_W +: TOK_W]), .cap(pir_burst[q*TOK_W +: TOK_W]),
            .need_len(head_len[q*LEN_W +: LEN_W]), .take(take[q]),
            .level(tok_pir[q*TOK_W +: TOK_W]), .enough(p_ok[q]));

        assign elig[q] = q_nonempty[q] && c_ok[q] && p_ok[q];
        assign take[q] = grant_now && (pick_idx == IDX_W'(q));

        // Service counter for this queue.
        always_ff @(posedge clk) begin
            if (!rst_n)       svc_count[q*CNT_W +: CNT_W] <= '0;
            else if (take[q]) svc_count[q*CNT_W +: CNT_W] <= svc_count[q*CNT_W +: CNT_W] + 1'b1;
        end

        p_svc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_valid && grant_idx == IDX_W'(q)) |->
                svc_count[q*CNT_W +: CNT_W] == $past(svc_count[q*CNT_W +: CNT_W]) + 1'b1);
        p_svc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !(grant_valid && grant_idx == IDX_W'(q)) |-> $stable(svc_count[q*CNT_W +: CNT_W]));
    end

    // Weighted classes.
    wdrr_pick #(.NW(NW), .LEN_W(LEN_W), .DEF_W(DEF_W)) u_wdrr (
        .clk(clk), .rst_n(rst_n),
        .nonempty(q_nonempty[NQ-1:1]), .elig(elig[NQ-1:1]),
        .head_len(head_len[NQ*LEN_W-1:LEN_W]), .quantum(quantum),
        .do_grant(dec == DEC_WEIGHTED), .do_refill(dec == DEC_REFILL),
        .has_cand(w_cand), .cand_idx(w_idx), .any_elig(w_any));

    // Guard: weighted classes take the slot once the strict run reaches MIN_SVC.
    assign force_w = (run_cnt >= RUN_W'(MIN_SVC)) && w_any;

    // Decision for this slot.
    always_comb begin
        if (elig[0] && !force_w) dec = DEC_STRICT;
        else if (w_cand)         dec = DEC_WEIGHTED;
        else if (w_any)          dec = DEC_REFILL;
        else                     dec = DEC_IDLE;
        grant_now = (dec == DEC_STRICT) || (dec == DEC_WEIGHTED);
        pick_idx  = (dec == DEC_STRICT) ? '0 : IDX_W'(w_idx) + IDX_W'(1);
    end

    // Consecutive strict-grant count, saturating at MIN_SVC.
    always_ff @(posedge clk) begin
        if (!rst_n)                  run_cnt <= '0;
        else if (dec == DEC_WEIGHTED) run_cnt <= '0;
        else if (dec == DEC_STRICT && run_cnt < RUN_W'(MIN_SVC))
            run_cnt <= run_cnt + 1'b1;
    end

    // Registered grant output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid <= 1'b0;
            grant_idx   <= '0;
        end else begin
            grant_valid <= grant_now;
            grant_idx   <= pick_idx;
        end
    end

    p_grant_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> |($past(elig) & (NQ'(1) << grant_idx)));
    p_strict_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(elig[0]) && $past(run_cnt) < RUN_W'(MIN_SVC)) |->
            (grant_valid && grant_idx == '0));
    p_min_service_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_idx == '0 && $past(w_any)) |-> $past(run_cnt) < RUN_W'(MIN_SVC));
endmodule

// File: tb/hybrid_sched_tb_top.sv
`timescale 1ns/1ps
module hybrid_sched_tb_top;
    localparam int NQ = 4, LEN_W = 12, TOK_W = 16, DEF_W = 16, CNT_W = 32, MIN_SVC = 3;
    localparam int IDX_W = $clog2(NQ);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [NQ-1:0]         q_nonempty = '0;
    logic [NQ*LEN_W-1:0]   head_len = '0;
    logic [NQ*TOK_W-1:0]   cir_inc = '0, cir_burst = '0, pir_inc = '0, pir_burst = '0;
    logic [(NQ-1)*DEF_W-1:0] quantum = '0;
    logic                  grant_valid;
    logic [IDX_W-1:0]      grant_idx;
    logic [NQ*CNT_W-1:0]   svc_count;
    logic [NQ*TOK_W-1:0]   tok_cir, tok_pir;

    int checks = 0, errors = 0;
    int gcount [NQ];
    int run = 0, max_run = 0, first_idx = -1;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hybrid_sched #(.NQ(NQ), .LEN_W(LEN_W), .TOK_W(TOK_W), .DEF_W(DEF_W),
                   .CNT_W(CNT_W), .MIN_SVC(MIN_SVC)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .q_nonempty(q_nonempty),
        .head_len(head_len), .cir_inc(cir_inc), .cir_burst(cir_burst),
        .pir_inc(pir_inc), .pir_burst(pir_burst), .quantum(quantum),
        .grant_valid(grant_valid), .grant_idx(grant_idx), .svc_count(svc_count),
        .tok_cir(tok_cir), .tok_pir(tok_pir));

    // Grant tally taken away from the active edge.
    always @(negedge clk) begin
        if (rst_n && grant_valid) begin
            gcount[grant_idx] = gcount[grant_idx] + 1;
            if (first_idx < 0) first_idx = int'(grant_idx);
            if (grant_idx == 0) begin
                run = run + 1;
                if (run > max_run) max_run = run;
            end else run = 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic set_q(input int q, input int cinc, input int cb, input int pinc, input int pb);
        cir_inc[q*TOK_W +: TOK_W]   = TOK_W'(cinc);
        cir_burst[q*TOK_W +: TOK_W] = TOK_W'(cb);
        pir_inc[q*TOK_W +: TOK_W]   = TOK_W'(pinc);
        pir_burst[q*TOK_W +: TOK_W] = TOK_W'(pb);
        head_len[q*LEN_W +: LEN_W]  = LEN_W'(100);
    endtask

    function automatic int svc(input int q);
        return int'(svc_count[q*CNT_W +: CNT_W]);
    endfunction
    function automatic int tc(input int q);
        return int'(tok_cir[q*TOK_W +: TOK_W]);
    endfunction
    function automatic int tp(input int q);
        return int'(tok_pir[q*TOK_W +: TOK_W]);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0; q_nonempty = '0;
        repeat (2) @(negedge clk);
        for (int q = 0; q < NQ; q++) gcount[q] = 0;
        run = 0; max_run = 0; first_idx = -1;
        rst_n = 1'b1;
        #1;
    endtask

    task automatic tick_n(input int n);
        repeat (n) begin @(negedge clk); tick = 1'b1; end
        @(negedge clk); tick = 1'b0;
        #1;
    endtask

    // R1: reset state.
    task automatic t_reset();
        for (int q = 0; q < NQ; q++) set_q(q, 500, 600, 500, 600);
        q_nonempty = '1; tick = 1'b1;
        cycles(10);
        do_reset();
        check(grant_valid == 1'b0, "R1 grant_valid", int'(grant_valid), 0);
        for (int q = 0; q < NQ; q++) begin
            check(svc(q) == 0, "R1 svc_count", svc(q), 0);
            check(tc(q) == 0 && tp(q) == 0, "R1 token levels", tc(q) + tp(q), 0);
        end
    endtask

    // R3: refill by increment and saturation at each burst size.
    task automatic t_refill();
        do_reset();
        set_q(1, 30, 100, 50, 120);
        tick_n(3);
        check(tc(1) == 90, "R3 committed refill", tc(1), 90);
        check(tp(1) == 120, "R3 peak saturation", tp(1), 120);
        tick_n(2);
        check(tc(1) == 100, "R3 committed saturation", tc(1), 100);
    endtask

    // R4: no grant below head length, then a debit of both buckets.
    task automatic t_elig();
        do_reset();
        set_q(1, 30, 1000, 400, 1000);
        quantum[0 +: DEF_W] = DEF_W'(1000);
        q_nonempty = 4'b0010;
        tick_n(3);
        check(svc(1) == 0 && gcount[1] == 0, "R4 short bucket blocks", svc(1), 0);
        tick_n(1);
        cycles(4);
        check(gcount[1] == 1, "R4 one grant once covered", gcount[1], 1);
        check(tc(1) == 20, "R4 committed debit", tc(1), 20);
        check(tp(1) == 900, "R4 peak debit", tp(1), 900);
        q_nonempty = '0;
    endtask

    // R5, R6, R2: strict precedence bounded by the guard.
    task automatic t_strict();
        do_reset();
        set_q(0, 1000, 60000, 1000, 60000);
        set_q(1, 1000, 60000, 1000, 60000);
        quantum[0 +: DEF_W] = DEF_W'(100);
        q_nonempty = 4'b0011; tick = 1'b1;
        cycles(100);
        tick = 1'b0; q_nonempty = '0;
        check(first_idx == 0, "R5 strict served first", first_idx, 0);
        check(max_run == MIN_SVC, "R6 longest strict run", max_run, MIN_SVC);
        check(gcount[1] >= 15, "R6 weighted minimum share", gcount[1], 15);
        check(gcount[2] == 0 && gcount[3] == 0, "R2 empty queues ungranted",
              gcount[2] + gcount[3], 0);
    endtask

    // R7, R8: deficit shares follow the quanta.
    task automatic t_drr();
        do_reset();
        for (int q = 1; q < NQ; q++) set_q(q, 1000, 60000, 1000, 60000);
        quantum = {DEF_W'(100), DEF_W'(200), DEF_W'(300)};
        q_nonempty = 4'b1110; tick = 1'b1;
        cycles(300);
        tick = 1'b0; q_nonempty = '0;
        cycles(2);
        check(gcount[3] >= 20, "R7 lightest queue served", gcount[3], 20);
        check(gcount[1] - 3*gcount[3] <= 3 && 3*gcount[3] - gcount[1] <= 3,
              "R7 share 3:1", gcount[1], 3*gcount[3]);
        check(gcount[2] - 2*gcount[3] <= 2 && 2*gcount[3] - gcount[2] <= 2,
              "R7 share 2:1", gcount[2], 2*gcount[3]);
        for (int q = 0; q < NQ; q++)
            check(svc(q) == gcount[q], "R8 counter matches grants", svc(q), gcount[q]);
    endtask

    // R9: strict rate cap and hand-over of unused cycles.
    task automatic t_cap();
        int g0, g1;
        do_reset();
        set_q(0, 10, 200, 1000, 60000);
        set_q(1, 1000, 60000, 1000, 60000);
        quantum[0 +: DEF_W] = DEF_W'(1000);
        q_nonempty = 4'b0001; tick = 1'b1;
        cycles(300);
        check(gcount[0] <= 32 && gcount[0] >= 25, "R9 strict capped alone", gcount[0], 30);
        g0 = gcount[0]; g1 = gcount[1];
        q_nonempty = 4'b0011;
        cycles(300);
        check(gcount[0] - g0 <= 32, "R9 strict capped with backlog", gcount[0] - g0, 32);
        check(gcount[1] - g1 >= 200, "R9 weighted gets spare cycles", gcount[1] - g1, 200);
        tick = 1'b0; q_nonempty = '0;
    endtask

    // R3, R4: the peak bucket limits when the committed one is ample.
    task automatic t_peak();
        do_reset();
        set_q(1, 1000, 60000, 20, 100);
        quantum[0 +: DEF_W] = DEF_W'(1000);
        q_nonempty = 4'b0010; tick = 1'b1;
        cycles(200);
        tick = 1'b0; q_nonempty = '0;
        cycles(1);
        check(gcount[1] >= 35 && gcount[1] <= 41, "R4 peak rate limits", gcount[1], 40);
        check(tp(1) <= 100, "R3 peak below burst", tp(1), 100);
    endtask

    initial begin
        t_reset();
        t_refill();
        t_elig();
        t_strict();
        t_drr();
        t_cap();
        t_peak();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule